// File: doc/BRIEF.md
# Two-Sided Doorbell Mailbox

The block joins a guest agent and a host agent, each with its own small register port. Either agent can post a short message of four 32-bit words to the other and raise a doorbell. Word 0 carries the request or event code and words 1 to 3 carry parameters. The receiver reads the sender's words through its own receive window and acknowledges by writing its receive control register. That acknowledge shows up in the sender's transmit control register, so the two sides complete a full handshake without any shared software state.

The acknowledge is cross-coupled. A sender's acknowledge flag is the peer's receive-acknowledge register. That register is forced clear one cycle after the sender withdraws its valid flag, so a new message always begins with the acknowledge flag low. Each side has two interrupt outputs: one pulses when a message arrives and one pulses when an acknowledge arrives. Each is gated by an enable bit in that side's interrupt control register.

Both sides use the same register port. It has a word address, a write strobe, byte enables and write data. Read data is combinational from the address in the same cycle. Writes take effect at the clock edge. The port has no stall or back-pressure: every access completes in one cycle. Both sides share one clock and an active-low asynchronous reset.

Top module: `dbell_mbox`

## Requirements
- R1: After reset every readable register on both sides reads 0 and all four interrupt outputs are low.
- R2: Word addresses 0 to 3 hold this side's transmit words and are written byte by byte under the byte enables (be[n] covers bits 8n+7:8n). The same words read back at the peer's addresses 8 to 11, in the same order.
- R3: A write to a transmit word while this side's valid flag is set leaves the word unchanged.
- R4: Address 4 is transmit control. Bit 0 is this side's valid flag, written through byte enable 0. Once the write's clock edge has passed, the peer reads the flag as bit 0 of its address 5.
- R5: Writing address 5 with bit 1 set (value 2) and byte enable 0 set, while the incoming valid flag is set, sets this side's receive-acknowledge, which reads as bit 1 of address 5. The sender sees it as bit 1 of its address 4 in the same cycle. The same write has no effect when the incoming valid flag is clear.
- R6: When a sender clears its valid flag, its acknowledge bit (address 4, bit 1) is still set in the next cycle, so address 4 reads 2. One cycle later it reads 0, together with the peer's receive-acknowledge.
- R7: The message interrupt of a side is high for exactly one cycle, namely the cycle after the edge where the incoming valid flag rose. It only fires when bit 0 of that side's interrupt control register (address 6) is set.
- R8: The acknowledge interrupt of a side is high for exactly one cycle, namely the cycle after the edge where its acknowledge flag rose. It only fires when bit 1 of address 6 is set.
- R9: Writes to the read-only acknowledge bit and to unused addresses (7, 12 to 15) have no effect, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| g_addr | input | 4 | Guest word address |
| g_we | input | 1 | Guest write strobe |
| g_be | input | 4 | Guest byte enables |
| g_wdata | input | 32 | Guest write data |
| g_rdata | output | 32 | Guest read data for g_addr |
| g_irq_msg | output | 1 | Guest message-arrived pulse |
| g_irq_ack | output | 1 | Guest acknowledge-arrived pulse |
| h_addr | input | 4 | Host word address |
| h_we | input | 1 | Host write strobe |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr |
| h_irq_msg | output | 1 | Host message-arrived pulse |
| h_irq_ack | output | 1 | Host acknowledge-arrived pulse |

## Verification
Reads are combinational, so a corrupted valid, receive-acknowledge or enable register shows up on the peer's control read in the very cycle after the faulty edge. A stale edge-detect register shows up as a missing or doubled interrupt pulse in that same cycle. A receive-acknowledge that fails to clear keeps the sender's address 4 at 2 or 3 beyond the one-cycle window. A word write that ignores the lock, or slips a byte enable, becomes visible at once through the peer's receive window.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // control bit positions shared by transmit and receive control registers
  localparam int unsigned FLAG_BIT = 0;
  localparam int unsigned ACK_BIT  = 1;
  // block numbers inside the per-side address space
  localparam int unsigned BLK_TX   = 0;
  localparam int unsigned BLK_CTL  = 1;
  localparam int unsigned BLK_RX   = 2;
  // register slots inside the control block
  localparam int unsigned SLOT_TXCTL = 0;
  localparam int unsigned SLOT_RXCTL = 1;
  localparam int unsigned SLOT_INT   = 2;
endpackage

// File: rtl/mbox_edge.sv
module mbox_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic enable,
  output logic pulse
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign pulse = enable & level & ~level_q;
endmodule

// File: rtl/mbox_side.sv
module mbox_side #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_WORDS = 4,   // power of two, at least 4
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              we,
  input  logic [DATA_W/8-1:0]               be,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output logic [N_WORDS-1:0][DATA_W-1:0]    tx_words,
  output logic                              tx_valid,
  input  logic [N_WORDS-1:0][DATA_W-1:0]    rx_words,
  input  logic                              rx_valid,
  input  logic                              peer_rack,
  output logic                              rack,
  output logic                              irq_msg,
  output logic                              irq_ack
);
  import mbox_pkg::*;

  localparam int unsigned BE_W  = DATA_W / 8;
  localparam int unsigned IDX_W = (N_WORDS > 4) ? $clog2(N_WORDS) : 2;
  localparam int unsigned BLK_W = ADDR_W - IDX_W;

  logic [BLK_W-1:0] blk;
  logic [IDX_W-1:0] idx;
  logic             ctl_wr0;
  logic             word_wr;
  logic [1:0]       int_en;

  assign blk     = addr[ADDR_W-1:IDX_W];
  assign idx     = addr[IDX_W-1:0];
  assign ctl_wr0 = we && be[0] && (blk == BLK_W'(BLK_CTL));
  assign word_wr = we && (blk == BLK_W'(BLK_TX)) && !tx_valid;

  // transmit words, locked while this side's message is posted
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_wr && idx == IDX_W'(w)) begin
        for (int b = 0; b < BE_W; b++) begin
          if (be[b]) word_q[b*8 +: 8] <= wdata[b*8 +: 8];
        end
      end
    end
    assign tx_words[w] = word_q;
  end

  // control state: own valid, receive-acknowledge, interrupt enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      rack     <= 1'b0;
      int_en   <= 2'b00;
    end else begin
      if (ctl_wr0 && idx == IDX_W'(SLOT_TXCTL)) tx_valid <= wdata[FLAG_BIT];
      if (!rx_valid)
        rack <= 1'b0;
      else if (ctl_wr0 && idx == IDX_W'(SLOT_RXCTL))
        rack <= wdata[ACK_BIT];
      if (ctl_wr0 && idx == IDX_W'(SLOT_INT)) int_en <= wdata[1:0];
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (blk == BLK_W'(BLK_TX)) begin
      rdata = tx_words[idx];
    end else if (blk == BLK_W'(BLK_RX)) begin
      rdata = rx_words[idx];
    end else if (blk == BLK_W'(BLK_CTL)) begin
      if (idx == IDX_W'(SLOT_TXCTL)) begin
        rdata[FLAG_BIT] = tx_valid;
        rdata[ACK_BIT]  = peer_rack;
      end else if (idx == IDX_W'(SLOT_RXCTL)) begin
        rdata[FLAG_BIT] = rx_valid;
        rdata[ACK_BIT]  = rack;
      end else if (idx == IDX_W'(SLOT_INT)) begin
        rdata[1:0] = int_en;
      end
    end
  end

  mbox_edge u_msg_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (rx_valid),
    .enable (int_en[0]),
    .pulse  (irq_msg)
  );

  mbox_edge u_ack_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (peer_rack),
    .enable (int_en[1]),
    .pulse  (irq_ack)
  );
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   g_addr,
  input  logic                g_we,
  input  logic [DATA_W/8-1:0] g_be,
  input  logic [DATA_W-1:0]   g_wdata,
  output logic [DATA_W-1:0]   g_rdata,
  output logic                g_irq_msg,
  output logic                g_irq_ack,
  input  logic [ADDR_W-1:0]   h_addr,
  input  logic                h_we,
  input  logic [DATA_W/8-1:0] h_be,
  input  logic [DATA_W-1:0]   h_wdata,
  output logic [DATA_W-1:0]   h_rdata,
  output logic                h_irq_msg,
  output logic                h_irq_ack
);
  logic [N_WORDS-1:0][DATA_W-1:0] g_words, h_words;
  logic g_valid, h_valid, g_rack, h_rack;

  mbox_side #(.DATA_W(DATA_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_guest (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (g_addr),
    .we        (g_we),
    .be        (g_be),
    .wdata     (g_wdata),
    .rdata     (g_rdata),
    .tx_words  (g_words),
    .tx_valid  (g_valid),
    .rx_words  (h_words),
    .rx_valid  (h_valid),
    .peer_rack (h_rack),
    .rack      (g_rack),
    .irq_msg   (g_irq_msg),
    .irq_ack   (g_irq_ack)
  );

  mbox_side #(.DATA_W(DATA_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (h_addr),
    .we        (h_we),
    .be        (h_be),
    .wdata     (h_wdata),
    .rdata     (h_rdata),
    .tx_words  (h_words),
    .tx_valid  (h_valid),
    .rx_words  (g_words),
    .rx_valid  (g_valid),
    .peer_rack (g_rack),
    .rack      (h_rack),
    .irq_msg   (h_irq_msg),
    .irq_ack   (h_irq_ack)
  );
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_WORDS = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           g_valid,
  input logic                           h_valid,
  input logic                           g_rack,
  input logic                           h_rack,
  input logic                           g_irq_msg,
  input logic                           h_irq_msg,
  input logic                           g_irq_ack,
  input logic                           h_irq_ack,
  input logic [N_WORDS-1:0][DATA_W-1:0] g_words,
  input logic [N_WORDS-1:0][DATA_W-1:0] h_words
);
  // R3
  g_words_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_valid && $past(g_valid)) |-> $stable(g_words));
  // R3
  h_words_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && $past(h_valid)) |-> $stable(h_words));
  // R5
  g_rack_needs_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(g_rack) |-> $past(h_valid));
  // R5
  h_rack_needs_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_rack) |-> $past(g_valid));
  // R6
  g_ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(g_valid) |=> !h_rack);
  // R6
  h_ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h_valid) |=> !g_rack);
  // R7
  g_msg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g_irq_msg |-> (h_valid && !$past(h_valid)));
  // R7
  h_msg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq_msg |=> !h_irq_msg);
  // R8
  g_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g_irq_ack |-> (h_rack && !$past(h_rack)));
  // R8
  h_ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq_ack |=> !h_irq_ack);
endmodule

bind dbell_mbox mbox_chk #(.DATA_W(DATA_W), .N_WORDS(N_WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .g_valid   (g_valid),
  .h_valid   (h_valid),
  .g_rack    (g_rack),
  .h_rack    (h_rack),
  .g_irq_msg (g_irq_msg),
  .h_irq_msg (h_irq_msg),
  .g_irq_ack (g_irq_ack),
  .h_irq_ack (h_irq_ack),
  .g_words   (g_words),
  .h_words   (h_words)
);

// File: tb/sim_dbell_mbox.sv
module sim_dbell_mbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  g_addr = '0, h_addr = '0;
  logic        g_we = 1'b0, h_we = 1'b0;
  logic [3:0]  g_be = '0, h_be = '0;
  logic [31:0] g_wdata = '0, h_wdata = '0;
  logic [31:0] g_rdata, h_rdata;
  logic        g_irq_msg, g_irq_ack, h_irq_msg, h_irq_ack;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // bench model of settled register state, index 0 guest, 1 host
  logic [31:0] mw [2][4];
  logic        mv [2];
  logic        mrack [2];
  logic [1:0]  men [2];

  always #10 clk = ~clk;

  dbell_mbox u0 (
    .clk(clk), .rst_n(rst_n),
    .g_addr(g_addr), .g_we(g_we), .g_be(g_be), .g_wdata(g_wdata),
    .g_rdata(g_rdata), .g_irq_msg(g_irq_msg), .g_irq_ack(g_irq_ack),
    .h_addr(h_addr), .h_we(h_we), .h_be(h_be), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_irq_msg(h_irq_msg), .h_irq_ack(h_irq_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 4; w++) mw[s][w] = '0;
      mv[s] = 1'b0; mrack[s] = 1'b0; men[s] = 2'b00;
    end
  endtask

  task automatic model_write(input int s, input logic [3:0] a, input logic [31:0] d,
                             input logic [3:0] b);
    int p = 1 - s;
    if (a < 4 && !mv[s]) begin
      for (int k = 0; k < 4; k++) if (b[k]) mw[s][a][k*8 +: 8] = d[k*8 +: 8];
    end
    if (a == 4 && b[0]) mv[s] = d[0];
    if (a == 5 && b[0]) mrack[s] = d[1] & mv[p];
    if (a == 6 && b[0]) men[s] = d[1:0];
    if (!mv[s]) mrack[p] = 1'b0;
  endtask

  function automatic logic [31:0] exp_read(input int s, input logic [3:0] a);
    int p = 1 - s;
    if (a < 4) return mw[s][a];
    if (a == 4) return {30'b0, mrack[p], mv[s]};
    if (a == 5) return {30'b0, mrack[s], mv[p]};
    if (a == 6) return {30'b0, men[s]};
    if (a >= 8 && a < 12) return mw[p][a - 8];
    return '0;
  endfunction

  task automatic wr(input int s, input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    if (s == 0) begin g_addr = a; g_wdata = d; g_be = b; g_we = 1'b1; end
    else        begin h_addr = a; h_wdata = d; h_be = b; h_we = 1'b1; end
    @(posedge clk);
    #1;
    g_we = 1'b0; h_we = 1'b0;
    model_write(s, a, d, b);
  endtask

  task automatic rd(input int s, input logic [3:0] a, output logic [31:0] v);
    if (s == 0) g_addr = a; else h_addr = a;
    #1;
    v = (s == 0) ? g_rdata : h_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned seed_init;
    seed_init = $urandom(32'd2024);
    do_reset();

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(0, 4'(a), v); chk("R1 guest reset read", v, 0);
      rd(1, 4'(a), v); chk("R1 host reset read", v, 0);
    end
    chk("R1 irqs low", {g_irq_msg, g_irq_ack, h_irq_msg, h_irq_ack}, 0);

    // R2 byte enables and peer window
    wr(0, 1, 32'hA5A5_1234, 4'b0101);
    rd(0, 1, v); chk("R2 guest word1 partial", v, 32'h00A5_0034);
    rd(1, 9, v); chk("R2 host sees word1", v, 32'h00A5_0034);
    wr(0, 0, 32'h1111_0001, 4'hF);
    rd(1, 8, v); chk("R2 host sees word0", v, 32'h1111_0001);
    wr(1, 3, 32'hCAFE_0003, 4'hF);
    rd(0, 11, v); chk("R2 guest sees host word3", v, 32'hCAFE_0003);

    // R9 read-only ack bit and unused addresses
    wr(0, 4, 32'h2, 4'hF);
    rd(0, 4, v); chk("R9 ack bit not writable", v, 0);
    wr(0, 7, 32'hFFFF_FFFF, 4'hF);
    wr(1, 12, 32'hFFFF_FFFF, 4'hF);
    rd(0, 7, v);  chk("R9 addr7 reads zero", v, 0);
    rd(1, 12, v); chk("R9 addr12 reads zero", v, 0);
    rd(0, 15, v); chk("R9 addr15 reads zero", v, 0);
    rd(0, 0, v);  chk("R9 words untouched", v, 32'h1111_0001);

    // enable both interrupts on both sides
    wr(1, 6, 32'h3, 4'hF);
    wr(0, 6, 32'h3, 4'hF);
    rd(0, 6, v); chk("R7 guest int ctl readback", v, 3);

    // R4 and R7 guest posts a message
    wr(0, 4, 32'h1, 4'h1);
    chk("R7 host msg irq pulse", h_irq_msg, 1);
    chk("R7 guest msg irq quiet", g_irq_msg, 0);
    rd(1, 5, v); chk("R4 host sees valid", v, 1);
    rd(0, 4, v); chk("R4 guest valid readback", v, 1);
    idle(1);
    chk("R7 host msg irq single cycle", h_irq_msg, 0);

    // R3 words locked while valid
    wr(0, 0, 32'hDEAD_BEEF, 4'hF);
    rd(0, 0, v); chk("R3 guest word0 locked", v, 32'h1111_0001);
    rd(1, 8, v); chk("R3 host view locked", v, 32'h1111_0001);

    // R5 and R8 host acknowledges
    wr(1, 5, 32'h2, 4'hF);
    chk("R8 guest ack irq pulse", g_irq_ack, 1);
    rd(0, 4, v); chk("R5 guest sees ack", v, 3);
    rd(1, 5, v); chk("R5 host rx ctl", v, 3);
    idle(1);
    chk("R8 guest ack irq single cycle", g_irq_ack, 0);

    // R6 dropping valid clears ack one cycle later
    wr(0, 4, 32'h0, 4'hF);
    rd(0, 4, v); chk("R6 ack lingers one cycle", v, 2);
    idle(1);
    rd(0, 4, v); chk("R6 ack cleared", v, 0);
    rd(1, 5, v); chk("R6 host rack cleared", v, 0);

    // R5 ack ignored without message
    wr(1, 5, 32'h2, 4'hF);
    rd(1, 5, v); chk("R5 ack ignored when idle", v, 0);
    rd(0, 4, v); chk("R5 guest no ack when idle", v, 0);
    chk("R8 no ack irq when idle", g_irq_ack, 0);

    // R7 disabled message interrupt
    wr(1, 6, 32'h2, 4'hF);
    wr(0, 4, 32'h1, 4'hF);
    chk("R7 masked msg irq", h_irq_msg, 0);
    wr(1, 5, 32'h2, 4'hF);
    chk("R8 enabled ack irq again", g_irq_ack, 1);
    wr(0, 4, 32'h0, 4'hF);
    idle(1);

    // R8 disabled acknowledge interrupt
    wr(0, 6, 32'h1, 4'hF);
    wr(0, 4, 32'h1, 4'hF);
    wr(1, 5, 32'h2, 4'hF);
    chk("R8 masked ack irq", g_irq_ack, 0);
    rd(0, 4, v); chk("R8 ack still visible", v, 3);
    wr(0, 4, 32'h0, 4'hF);
    idle(1);

    // R7 host to guest direction
    wr(1, 4, 32'h1, 4'hF);
    chk("R7 guest msg irq pulse", g_irq_msg, 1);
    rd(0, 11, v); chk("R2 guest reads host word3", v, 32'hCAFE_0003);
    wr(1, 4, 32'h0, 4'hF);
    idle(1);

    // random phase against the bench model
    do_reset();
    for (int it = 0; it < 400; it++) begin
      int s;
      logic [3:0] a;
      logic [31:0] d;
      logic [3:0] b;
      s = int'($urandom_range(0, 1));
      a = 4'($urandom_range(0, 15));
      d = $urandom();
      b = 4'($urandom_range(0, 15));
      wr(s, a, d, b);
      idle(1);
      for (int k = 0; k < 16; k++) begin
        rd(0, 4'(k), v); chk("R2 R3 R4 R5 R6 R9 random guest", v, exp_read(0, 4'(k)));
        rd(1, 4'(k), v); chk("R2 R3 R4 R5 R6 R9 random host", v, exp_read(1, 4'(k)));
      end
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule